// File: doc/BRIEF.md
# Multiplexed Grid/Anode Display Scanner with Key Matrix Readout

The block drives a time-multiplexed grid-and-anode display. A frame is a sequence of slots. Each display slot selects one grid line and drives the anode lines with that slot's pattern, which is fetched from an external display RAM. Each slot opens with a blank gap in which every output is off. The gap is followed by a lit window whose length is set by a dimmer value, and the slot may end with a dark tail. Sixteen of the grid pins can each be switched to carry an extra anode bit instead of a grid select.

When key scanning is enabled, sixteen extra slots follow the display slots in each frame. In each of these slots a single anode line is raised as a scan line, and the eight key-return inputs are captured at the close of the slot into a row byte. A row whose captured byte differs from the byte stored before raises a one-cycle interrupt pulse and a sticky change flag, which stays set until it is acknowledged. Software reads any row through a row selector.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: While `cfg_en` is 0, every grid and anode output is 0. One clock edge after `cfg_en` falls, `ram_addr_o` reads 0 and the sequence restarts from display slot 0 with its gap.
- R2: The number of display slots per frame is `cfg_timings` limited to the range 1..20. A value of 0 acts as 1 and a value above 20 acts as 20. Display slots appear in ascending order from 0, and `ram_addr_o` equals the slot number.
- R3: A tick occurs every `cfg_presc`+1 clocks. A slot lasts `cfg_slot_len`+2 ticks. After the last slot of a frame the sequence wraps to slot 0.
- R4: During the first tick of every slot, all grid and anode outputs are 0.
- R5: The lit window begins on the second tick of a slot and lasts min(`cfg_dim`+1, slot ticks − 1) ticks. Outputs are 0 for the rest of the slot.
- R6: During the lit window of display slot t, grid pin t is 1 if it is in grid mode, and every other grid-mode pin is 0. Pins 16..19 are always in grid mode.
- R7: A dual pin i (i < 16) with `cfg_dual_seg[i]`=1 drives bit 32+i of the RAM word during the lit window of every display slot.
- R8: During the lit window of a display slot, `seg_o` equals bits 31..0 of the RAM word for that slot. The RAM word is read with one clock of latency.
- R9: With `cfg_key_en`=1, sixteen key slots k=0..15 follow the display slots. During their lit windows the grids are 0 and `seg_o` is 1<<k.
- R10: At the last clock of key slot k, `key_ret_i` is stored as row k. `key_data_o` shows the row chosen by `key_sel_i`. All rows reset to 0.
- R11: A stored row that differs from its previous value produces a one-clock `key_irq_o` pulse in the next cycle and sets `key_chg_o`. `key_ack_i` clears `key_chg_o`. A repeat scan with unchanged keys produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Display scanning enable |
| cfg_timings | input | 5 | Requested display slot count |
| cfg_slot_len | input | 4 | Slot length minus 2, in ticks |
| cfg_dim | input | 4 | Lit window length minus 1, in ticks |
| cfg_presc | input | 8 | Clocks per tick minus 1 |
| cfg_dual_seg | input | 16 | Per dual pin: 1 = anode mode, 0 = grid mode |
| cfg_key_en | input | 1 | Appends sixteen key scan slots to each frame |
| ram_addr_o | output | 5 | Display RAM read address |
| ram_rdata_i | input | 48 | Display RAM word, one clock after the address |
| grid_o | output | 20 | Grid outputs (pins 0..15 dual purpose) |
| seg_o | output | 32 | Anode outputs |
| key_ret_i | input | 8 | Key return lines |
| key_sel_i | input | 4 | Key row selector |
| key_data_o | output | 8 | Selected key row |
| key_chg_o | output | 1 | Sticky key change flag |
| key_irq_o | output | 1 | One-clock key change pulse |
| key_ack_i | input | 1 | Clears the change flag |

## Verification
The bench measures every lit window's pattern and exact length in clocks against an ordered list of expected windows, so the following faults all show up: an off-by-one in the gap, a dimmer that is not capped at the slot length, a slot count that is not limited to 1..20, or a RAM word taken one slot late. Dual pins are run in a mixed mode mask with all twenty slots. If the grid and anode roles of those pins were swapped, or if a grid beyond pin 15 were lost, the windows would mismatch. A slow prescaler combined with the minimum slot length checks that ticks, not clocks, set the window widths. For the key matrix, the bench answers the scan lines as a real keypad would. It then checks that only the rows that changed produce interrupts, and that a second identical scan is silent. A design that compared against the wrong row, or raised an interrupt on every sample, would produce the wrong pulse count.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  // Limit a requested slot count to 1..max_t.
  function automatic int clamp_timings(int req, int max_t);
    if (req < 1) return 1;
    if (req > max_t) return max_t;
    return req;
  endfunction

  // Lit ticks: dimmer value plus one, capped at the ticks after the gap.
  function automatic int lit_ticks(int dim, int slot_ticks);
    int want;
    want = dim + 1;
    return (want < slot_ticks - 1) ? want : slot_ticks - 1;
  endfunction
endpackage

// File: rtl/vfd_tick_gen.sv
module vfd_tick_gen #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] presc,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt;

  assign tick_o = en && (cnt >= presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vfd_slot_seq.sv
module vfd_slot_seq #(
  parameter int SLOT_W   = 6,
  parameter int TNUM_W   = 5,
  parameter int CNT_W    = 5,
  parameter int KEY_ROWS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [TNUM_W-1:0] n_tim,
  input  logic              key_en,
  input  logic [CNT_W-1:0]  slot_ticks,
  input  logic [CNT_W-1:0]  lit,
  output logic [SLOT_W-1:0] slot_o,
  output logic [CNT_W-1:0]  tcnt_o,
  output logic              lit_o,
  output logic              key_slot_o,
  output logic              slot_end_o
);
  logic [SLOT_W-1:0] last_slot;

  assign last_slot  = SLOT_W'(n_tim) + (key_en ? SLOT_W'(KEY_ROWS) : '0) - SLOT_W'(1);
  assign slot_end_o = tick && (tcnt_o == slot_ticks - CNT_W'(1));
  assign lit_o      = en && (tcnt_o != '0) && (tcnt_o <= lit);
  assign key_slot_o = slot_o >= SLOT_W'(n_tim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_o <= '0;
      tcnt_o <= '0;
    end else if (!en) begin
      slot_o <= '0;
      tcnt_o <= '0;
    end else if (slot_end_o) begin
      tcnt_o <= '0;
      slot_o <= (slot_o >= last_slot) ? '0 : slot_o + 1'b1;
    end else if (tick) begin
      tcnt_o <= tcnt_o + 1'b1;
    end
  end

  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    en && slot_end_o && (slot_o == last_slot) |=> slot_o == '0);
  a_r5_lit_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lit_o) |-> tcnt_o == CNT_W'(1));
endmodule

// File: rtl/vfd_key_scan.sv
module vfd_key_scan #(
  parameter int KEY_ROWS = 16,
  parameter int KEY_W    = 8,
  parameter int ROW_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic [ROW_W-1:0] row,
  input  logic [KEY_W-1:0] ret,
  input  logic [ROW_W-1:0] sel,
  input  logic             ack,
  output logic [KEY_W-1:0] data_o,
  output logic             chg_o,
  output logic             irq_o
);
  logic [KEY_W-1:0] keybuf [KEY_ROWS];
  logic             differs;

  assign differs = sample && (ret != keybuf[row]);
  assign data_o  = keybuf[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < KEY_ROWS; r++) keybuf[r] <= '0;
      chg_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (sample) keybuf[row] <= ret;
      irq_o <= differs;
      if (differs)  chg_o <= 1'b1;
      else if (ack) chg_o <= 1'b0;
    end
  end

  a_r10_row_stored: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> keybuf[$past(row)] == $past(ret));
  a_r11_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !ack |=> chg_o);
endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
  import vfd_pkg::*;
#(
  parameter  int MAX_TIM  = 20,
  parameter  int DUAL_W   = 16,
  parameter  int SEG_W    = 32,
  parameter  int KEY_ROWS = 16,
  parameter  int KEY_W    = 8,
  parameter  int PRE_W    = 8,
  parameter  int LEN_W    = 4,
  parameter  int DIM_W    = 4,
  localparam int TNUM_W   = $clog2(MAX_TIM + 1),
  localparam int ADDR_W   = $clog2(MAX_TIM),
  localparam int ROW_W    = $clog2(KEY_ROWS),
  localparam int RAM_W    = SEG_W + DUAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [TNUM_W-1:0] cfg_timings,
  input  logic [LEN_W-1:0]  cfg_slot_len,
  input  logic [DIM_W-1:0]  cfg_dim,
  input  logic [PRE_W-1:0]  cfg_presc,
  input  logic [DUAL_W-1:0] cfg_dual_seg,
  input  logic              cfg_key_en,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [RAM_W-1:0]  ram_rdata_i,
  output logic [MAX_TIM-1:0] grid_o,
  output logic [SEG_W-1:0]  seg_o,
  input  logic [KEY_W-1:0]  key_ret_i,
  input  logic [ROW_W-1:0]  key_sel_i,
  output logic [KEY_W-1:0]  key_data_o,
  output logic              key_chg_o,
  output logic              key_irq_o,
  input  logic              key_ack_i
);
  localparam int SLOT_W = $clog2(MAX_TIM + KEY_ROWS);
  localparam int CNT_W  = LEN_W + 1;

  logic [TNUM_W-1:0] n_tim;
  logic [CNT_W-1:0]  slot_ticks, lit;
  logic              tick, lit_on, key_slot, slot_end, disp_on, key_on;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  tcnt;
  logic [ROW_W-1:0]  key_row;
  logic [SEG_W-1:0]  key_pat;

  assign n_tim      = TNUM_W'(clamp_timings(int'(cfg_timings), MAX_TIM));
  assign slot_ticks = CNT_W'(int'(cfg_slot_len) + 2);
  assign lit        = CNT_W'(lit_ticks(int'(cfg_dim), int'(cfg_slot_len) + 2));

  vfd_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .presc(cfg_presc), .tick_o(tick));

  vfd_slot_seq #(.SLOT_W(SLOT_W), .TNUM_W(TNUM_W), .CNT_W(CNT_W), .KEY_ROWS(KEY_ROWS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .tick(tick), .n_tim(n_tim),
    .key_en(cfg_key_en), .slot_ticks(slot_ticks), .lit(lit), .slot_o(slot),
    .tcnt_o(tcnt), .lit_o(lit_on), .key_slot_o(key_slot), .slot_end_o(slot_end));

  assign key_row    = ROW_W'(slot - SLOT_W'(n_tim));
  assign disp_on    = lit_on && !key_slot;
  assign key_on     = lit_on && key_slot;
  assign key_pat    = SEG_W'(1) << key_row;
  assign ram_addr_o = key_slot ? '0 : ADDR_W'(slot);
  assign seg_o      = disp_on ? ram_rdata_i[SEG_W-1:0] : (key_on ? key_pat : '0);

  for (genvar gi = 0; gi < MAX_TIM; gi++) begin : g_grid
    if (gi < DUAL_W) begin : g_dual
      assign grid_o[gi] = disp_on &&
        (cfg_dual_seg[gi] ? ram_rdata_i[SEG_W+gi] : (slot == SLOT_W'(gi)));
    end else begin : g_only
      assign grid_o[gi] = disp_on && (slot == SLOT_W'(gi));
    end
  end

  vfd_key_scan #(.KEY_ROWS(KEY_ROWS), .KEY_W(KEY_W), .ROW_W(ROW_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .sample(slot_end && key_slot), .row(key_row),
    .ret(key_ret_i), .sel(key_sel_i), .ack(key_ack_i), .data_o(key_data_o),
    .chg_o(key_chg_o), .irq_o(key_irq_o));

  a_r1_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (grid_o == '0) && (seg_o == '0));
  a_r1_off_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (slot == '0) && (tcnt == '0));
  a_r4_gap_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt == '0) |-> (grid_o == '0) && (seg_o == '0));
  a_r9_key_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |-> (grid_o == '0) && ($countones(seg_o) == 1));
endmodule

// File: tb/tb_vfd_scan_ctrl.sv
`timescale 1ns/1ps
module tb_vfd_scan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [4:0]  cfg_timings = '0;
  logic [3:0]  cfg_slot_len = '0;
  logic [3:0]  cfg_dim = '0;
  logic [7:0]  cfg_presc = '0;
  logic [15:0] cfg_dual_seg = '0;
  logic        cfg_key_en = 1'b0;
  logic [4:0]  ram_addr_o;
  logic [47:0] ram_rdata_i = '0;
  logic [19:0] grid_o;
  logic [31:0] seg_o;
  logic [7:0]  key_ret_i = '0;
  logic [3:0]  key_sel_i = '0;
  logic [7:0]  key_data_o;
  logic        key_chg_o, key_irq_o;
  logic        key_ack_i = 1'b0;

  always #2.5 clk = ~clk;

  vfd_scan_ctrl dut (.*);

  typedef struct { logic [51:0] pat; int len; string tag; } win_t;
  win_t q[$];
  int   n_tests = 0, n_fail = 0, cycles = 0, irq_cnt = 0;
  bit   armed = 0;
  logic [7:0] matrix [16];

  function automatic logic [31:0] seg_of(int t);
    return {8'(t + 1), 8'hC3, ~8'(t), 8'(t * 7 + 1)};
  endfunction
  function automatic logic [15:0] extra_of(int t);
    return 16'h09A5 ^ 16'(t * 16'h0111);
  endfunction

  // Display RAM with one clock of read latency
  always @(posedge clk) ram_rdata_i <= {extra_of(int'(ram_addr_o)), seg_of(int'(ram_addr_o))};

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Keypad model: answers a single raised scan line
  always @(negedge clk) begin
    logic [7:0] v;
    v = '0;
    if (grid_o == '0 && seg_o[31:16] == '0 && $countones(seg_o[15:0]) == 1)
      for (int k = 0; k < 16; k++) if (seg_o[k]) v = matrix[k];
    key_ret_i <= v;
    if (key_irq_o) irq_cnt++;
  end

  // Monitor: measures each lit window and compares with the queue
  bit          in_win = 0, win_valid = 0;
  logic [51:0] win_pat;
  int          win_len;
  always @(negedge clk) begin
    logic [51:0] cur;
    win_t it;
    cur = {grid_o, seg_o};
    if (cur != '0) begin
      if (!in_win) begin
        in_win = 1; win_pat = cur; win_len = 1;
        win_valid = armed && (q.size() > 0);
      end else begin
        win_len++;
        if (win_valid && cur != win_pat)
          check(0, "R8 pattern changed inside window", 64'(cur), 64'(win_pat));
      end
    end else if (in_win) begin
      in_win = 0;
      if (win_valid) begin
        it = q.pop_front();
        check(win_pat == it.pat, {it.tag, " pattern"}, 64'(win_pat), 64'(it.pat));
        check(win_len == it.len, {it.tag, " R5 lit length"}, 64'(win_len), 64'(it.len));
      end
    end
  end

  // Driver: pushes the windows the requirements predict, then runs
  task automatic run(int tim, int len, int dim, int presc, logic [15:0] mask,
                     bit key, int frames, string tag);
    int n, lit, clk_len;
    win_t it;
    n = (tim < 1) ? 1 : ((tim > 20) ? 20 : tim);               // R2
    lit = (dim + 1 < len + 1) ? dim + 1 : len + 1;            // R5
    clk_len = lit * (presc + 1);                               // R3
    for (int f = 0; f < frames; f++) begin
      for (int t = 0; t < n; t++) begin
        logic [19:0] g;
        for (int i = 0; i < 20; i++)                           // R6, R7
          g[i] = (i < 16 && mask[i]) ? extra_of(t)[i] : (i == t);
        it.pat = {g, seg_of(t)}; it.len = clk_len;             // R8
        it.tag = $sformatf("%s R6 R7 R8 slot %0d", tag, t);
        q.push_back(it);
      end
      if (key)
        for (int k = 0; k < 16; k++) begin                     // R9
          it.pat = {20'b0, 32'(1) << k}; it.len = clk_len;
          it.tag = $sformatf("%s R9 key slot %0d", tag, k);
          q.push_back(it);
        end
    end
    @(negedge clk);
    cfg_timings = 5'(tim); cfg_slot_len = 4'(len); cfg_dim = 4'(dim);
    cfg_presc = 8'(presc); cfg_dual_seg = mask; cfg_key_en = key;
    armed = 1; cfg_en = 1;
    while (q.size() != 0) @(negedge clk);
    armed = 0; cfg_en = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < 16; r++) matrix[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(grid_o == '0 && seg_o == '0, "R1 reset outputs dark", 64'({grid_o, seg_o}), 0);
    check(key_data_o == '0 && !key_chg_o && !key_irq_o, "R10 R11 reset key state",
          64'({key_data_o, key_chg_o, key_irq_o}), 0);

    run(4, 4, 2, 0, 16'h0000, 0, 2, "S1 dimmed");
    check(grid_o == '0 && seg_o == '0 && ram_addr_o == '0, "R1 disabled",
          64'({ram_addr_o, grid_o, seg_o}), 0);
    run(31, 2, 1, 0, 16'hF0F0, 0, 1, "S2 clamp20 mixed");
    run(0, 0, 0, 2, 16'h0000, 0, 3, "S3 clamp1 prescaled");
    run(3, 4, 15, 0, 16'h0005, 0, 1, "S4 full dim");

    matrix[3] = 8'hA5; matrix[15] = 8'h01;
    irq_cnt = 0;
    run(2, 3, 15, 0, 16'h0000, 1, 1, "S5 keys");
    repeat (4) @(negedge clk);
    check(irq_cnt == 2, "R11 irq per changed row", 64'(irq_cnt), 2);
    check(key_chg_o == 1'b1, "R11 change flag set", 64'(key_chg_o), 1);
    for (int r = 0; r < 16; r++) begin
      key_sel_i = 4'(r); #1;
      check(key_data_o == matrix[r], $sformatf("R10 row %0d", r), 64'(key_data_o), 64'(matrix[r]));
    end
    key_ack_i = 1; @(negedge clk); key_ack_i = 0;
    check(key_chg_o == 1'b0, "R11 ack clears flag", 64'(key_chg_o), 0);
    irq_cnt = 0;
    run(2, 3, 15, 0, 16'h0000, 1, 1, "S6 keys repeat");
    repeat (4) @(negedge clk);
    check(irq_cnt == 0 && !key_chg_o, "R11 no change no irq", 64'(irq_cnt), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule